// File: doc/BRIEF.md
# Watchdog Timer with Assignable Postscaler

This block is a watchdog for a small controller. It counts ticks from a slow, independent oscillator that keeps running while the core clock is gated in sleep. Software must restart the count with a clear strobe before it reaches its limit. If the count reaches the limit, the block issues a device reset pulse and drops a time-out status bit. Entering sleep also restarts the count, so a sleeping device always gets the full interval before a watchdog wake-up. A time-out that happens during sleep is flagged with a one-cycle wake indication.

An 8-bit postscaler is shared between this watchdog and a general timer, and an ownership bit decides which of the two uses it. When the watchdog owns it, each overflow of the base count advances the postscaler. A 3-bit ratio field then stretches the timeout by a power of two, from 1 up to 128. The block's clock `clk` is assumed always on. The oscillator's ticks arrive as single-cycle enables in that domain. All strobes are one `clk` cycle wide.

Top module: `wdog_guard`

## Requirements
- R1: After power-on reset, `dev_rst` is 0, `to_flag` is 1 and `wake` is 0.
- R2: With `ps_to_wdog`=0, the BASE_TICKS-th counted tick after a restart starts a time-out. `dev_rst` goes to 1 in the cycle after the edge that samples that tick.
- R3: With `ps_to_wdog`=1, the ratio field value r (0 to 7) selects division by 2^r. A time-out then follows BASE_TICKS*2^r counted ticks.
- R4: A time-out drives `dev_rst` high for exactly RST_CYCLES cycles and clears `to_flag` to 0 at the same edge. While `dev_rst` is high, ticks, clear strobes and sleep strobes are ignored, and both counts are held at zero.
- R5: While `wd_enable` is 0, ticks are ignored and the counts are frozen. No time-out can start.
- R6: `clr_wdog` restarts the base count, and it also restarts the postscaler when `ps_to_wdog`=1. It sets `to_flag` to 1 one cycle later.
- R7: `sleep_enter` restarts the counts in the same way as `clr_wdog` but leaves `to_flag` unchanged. The next time-out raises `wake` for one cycle, in the same cycle that `dev_rst` rises.
- R8: Any change of `ps_to_wdog` clears the postscaler. A tick that arrives in the same cycle as a clear strobe, a sleep strobe or an ownership change is discarded.
- R9: If the ratio is lowered below the current postscaler count, the next base overflow causes a time-out.
- R10: Once cleared, `to_flag` stays 0 until `clr_wdog` is accepted or a power-on reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Power-on reset, active low |
| wd_tick | input | 1 | One-cycle tick from the independent oscillator |
| wd_enable | input | 1 | 1 lets the watchdog count |
| ps_to_wdog | input | 1 | Postscaler owner: 1 watchdog, 0 timer |
| ps_ratio | input | 3 | Postscaler division exponent r, divide by 2^r |
| clr_wdog | input | 1 | Watchdog clear strobe |
| sleep_enter | input | 1 | Sleep-entry strobe |
| dev_rst | output | 1 | Device reset pulse, RST_CYCLES long |
| to_flag | output | 1 | Time-out status, 0 after a time-out |
| wake | output | 1 | One-cycle wake indication for a time-out during sleep |

## Verification
A base count that is wrong by even one tick moves the rise of `dev_rst` by one tick interval. A wrong postscaler count moves it by whole multiples of BASE_TICKS ticks. Both faults show up at the first time-out after the fault, so the bench runs each scenario up to the exact tick where the time-out is due and checks the output one tick before and at that tick. Errors in the reset pulse length, in the status bit or in the sleep state appear within a few cycles as a mismatch on `dev_rst`, `to_flag` or `wake`. The reference model compares these outputs every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int PS_W    = 8;
    localparam int RATIO_W = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    // postscaler state: running count and last seen owner bit
    typedef struct packed {
        logic [PS_W-1:0] cnt;
        logic            owner_prev;
    } post_state_t;
endpackage

// File: rtl/wdog_base.sv
// Base tick counter: raises ovf on the tick that completes BASE_TICKS.
module wdog_base #(
    parameter int BASE_TICKS = 288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic ovf
);
    localparam int CW = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } base_state_t;

    base_state_t q, d;

    assign ovf = tick && !clear && (q.cnt == LAST);

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = ovf ? '0 : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wdog_post.sv
// Shared postscaler, watchdog side (R3, R8, R9).
module wdog_post
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ovf,
    input  logic   owned,
    input  ratio_t ratio,
    input  logic   clear_req,
    input  logic   hold_rst,
    output logic   owner_chg,
    output logic   expire
);
    post_state_t q, d;
    logic [PS_W-1:0] lim;
    logic            at_lim;

    assign owner_chg = (owned != q.owner_prev);
    // 2^r - 1 as terminal count (R3)
    assign lim    = ~({PS_W{1'b1}} << ratio);
    // >= so a lowered ratio ends at the next overflow (R9)
    assign at_lim = (q.cnt >= lim);
    assign expire = ovf && (!owned || at_lim);

    always_comb begin
        d            = q;
        d.owner_prev = owned;
        if (hold_rst || owner_chg || (clear_req && owned)) begin
            d.cnt = '0;                                  // R8
        end else if (ovf && owned) begin
            d.cnt = at_lim ? '0 : q.cnt + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wdog_rstgen.sv
// Reset pulse, status bit and sleep tracking (R4, R6, R7, R10).
module wdog_rstgen #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_ok,
    input  logic sleep_ok,
    output logic dev_rst,
    output logic to_flag,
    output logic wake
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [RW-1:0] PULSE = RW'(RST_CYCLES);

    typedef struct packed {
        logic [RW-1:0] left;
        logic          flag;
        logic          asleep;
        logic          wake;
    } rst_state_t;

    rst_state_t q, d;

    always_comb begin
        d      = q;
        d.wake = 1'b0;
        if (q.left != '0) begin
            d.left = q.left - RW'(1);
        end else begin
            if (clr_ok)   d.flag   = 1'b1;
            if (sleep_ok) d.asleep = 1'b1;
            if (expire) begin
                d.left   = PULSE;
                d.flag   = 1'b0;
                d.wake   = q.asleep;
                d.asleep = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{left: '0, flag: 1'b1, asleep: 1'b0, wake: 1'b0}; // R1
        else        q <= d;
    end

    assign dev_rst = (q.left != '0);
    assign to_flag = q.flag;
    assign wake    = q.wake;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 288,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_tick,
    input  logic       wd_enable,
    input  logic       ps_to_wdog,
    input  logic [2:0] ps_ratio,
    input  logic       clr_wdog,
    input  logic       sleep_enter,
    output logic       dev_rst,
    output logic       to_flag,
    output logic       wake
);
    logic in_rst, clr_ok, sleep_ok, owner_chg, tick_ok, ovf, expire;

    assign clr_ok   = clr_wdog    && !in_rst;
    assign sleep_ok = sleep_enter && !in_rst;
    // a tick coinciding with any restart is dropped (R8); disabled stops counting (R5)
    assign tick_ok  = wd_tick && wd_enable && !in_rst && !clr_ok && !sleep_ok && !owner_chg;

    wdog_base #(.BASE_TICKS(BASE_TICKS)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (in_rst || clr_ok || sleep_ok),
        .tick  (tick_ok),
        .ovf   (ovf)
    );

    wdog_post u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf       (ovf),
        .owned     (ps_to_wdog),
        .ratio     (ratio_t'(ps_ratio)),
        .clear_req (clr_ok || sleep_ok),
        .hold_rst  (in_rst),
        .owner_chg (owner_chg),
        .expire    (expire)
    );

    wdog_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .clr_ok   (clr_ok),
        .sleep_ok (sleep_ok),
        .dev_rst  (dev_rst),
        .to_flag  (to_flag),
        .wake     (wake)
    );

    assign in_rst = dev_rst;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic wd_tick,
    input logic wd_enable,
    input logic clr_wdog,
    input logic dev_rst,
    input logic to_flag,
    input logic wake
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (dev_rst) hi_cnt <= hi_cnt + 16'd1;
        else              hi_cnt <= '0;
    end

    assert_pulse_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |-> (hi_cnt < 16'(RST_CYCLES)));

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_rst) |-> (hi_cnt == 16'(RST_CYCLES)));

    assert_flag_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst) |-> !to_flag);

    assert_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_tick |=> !$rose(dev_rst));

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !$rose(dev_rst));

    assert_clear_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdog && !dev_rst) |=> to_flag);

    assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $rose(dev_rst));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_flag && !(clr_wdog && !dev_rst)) |=> !to_flag);
endmodule

bind wdog_guard wdog_guard_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_tick   (wd_tick),
    .wd_enable (wd_enable),
    .clr_wdog  (clr_wdog),
    .dev_rst   (dev_rst),
    .to_flag   (to_flag),
    .wake      (wake)
);

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;
    localparam int BASE = 5;
    localparam int RSTC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_tick = 1'b0, wd_enable = 1'b1, ps_to_wdog = 1'b0;
    logic [2:0] ps_ratio = 3'd0;
    logic clr_wdog = 1'b0, sleep_enter = 1'b0;
    logic dev_rst, to_flag, wake;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wdog_guard #(.BASE_TICKS(BASE), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .wd_enable(wd_enable),
        .ps_to_wdog(ps_to_wdog), .ps_ratio(ps_ratio), .clr_wdog(clr_wdog),
        .sleep_enter(sleep_enter), .dev_rst(dev_rst), .to_flag(to_flag), .wake(wake)
    );

    // behavioural reference model
    int m_base, m_ps, m_left;
    bit m_flag, m_sleep, m_wake, m_prev;

    always @(posedge clk) begin
        bit fire;
        bit chg;
        fire = 0;
        if (!rst_n) begin
            m_base = 0; m_ps = 0; m_left = 0;
            m_flag = 1; m_sleep = 0; m_wake = 0; m_prev = 0;
        end else begin
            m_wake = 0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                m_base = 0; m_ps = 0;
                m_prev = ps_to_wdog;
            end else begin
                chg = (ps_to_wdog != m_prev);
                m_prev = ps_to_wdog;
                if (clr_wdog) m_flag = 1;
                if (clr_wdog || sleep_enter) begin
                    m_base = 0;
                    if (ps_to_wdog) m_ps = 0;
                end
                if (sleep_enter) m_sleep = 1;
                if (chg) m_ps = 0;
                if (!clr_wdog && !sleep_enter && !chg && wd_tick && wd_enable) begin
                    if (m_base == BASE - 1) begin
                        m_base = 0;
                        if (!ps_to_wdog) fire = 1;
                        else if (m_ps >= (1 << ps_ratio) - 1) begin m_ps = 0; fire = 1; end
                        else m_ps = m_ps + 1;
                    end else m_base = m_base + 1;
                end
                if (fire) begin
                    m_left = RSTC; m_flag = 0; m_wake = m_sleep; m_sleep = 0;
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(dev_rst, (m_left > 0), "R2/R3/R4 model dev_rst");
            chk(to_flag, m_flag, "R6/R10 model to_flag");
            chk(wake, m_wake, "R7 model wake");
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) wd_tick = 1'b1;
            @(negedge clk) wd_tick = 1'b0;
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_wdog = 1'b1;
        @(negedge clk) clr_wdog = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_enter = 1'b1;
        @(negedge clk) sleep_enter = 1'b0;
    endtask

    task automatic recover();
        repeat (RSTC + 2) @(negedge clk);
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_rst, 1'b0, "R1 reset dev_rst");
        chk(to_flag, 1'b1, "R1 reset to_flag");
        chk(wake, 1'b0, "R1 reset wake");

        // R2 base timeout, R4 pulse, R10 flag hold
        ticks(BASE - 1);
        chk(dev_rst, 1'b0, "R2 before limit");
        ticks(1);
        chk(dev_rst, 1'b1, "R2 at limit");
        chk(to_flag, 1'b0, "R4 flag cleared");
        chk(wake, 1'b0, "R7 no wake when awake");
        repeat (RSTC - 1) @(negedge clk);
        chk(dev_rst, 1'b1, "R4 last pulse cycle");
        @(negedge clk);
        chk(dev_rst, 1'b0, "R4 pulse ended");
        repeat (5) @(negedge clk);
        chk(to_flag, 1'b0, "R10 flag held low");
        pulse_clr();
        chk(to_flag, 1'b1, "R10 clear restores flag");

        // R3 postscaler 1:4
        @(negedge clk) begin ps_to_wdog = 1'b1; ps_ratio = 3'd2; end
        pulse_clr();
        ticks(4 * BASE - 1);
        chk(dev_rst, 1'b0, "R3 before scaled limit");
        ticks(1);
        chk(dev_rst, 1'b1, "R3 scaled limit");
        recover();

        // R9 ratio lowered below the running count
        ps_ratio = 3'd3;
        ticks(3 * BASE);
        ps_ratio = 3'd1;
        ticks(BASE - 1);
        chk(dev_rst, 1'b0, "R9 before overflow");
        ticks(1);
        chk(dev_rst, 1'b1, "R9 expires at next overflow");
        recover();

        // R8 ownership change clears postscaler
        ticks(BASE);
        @(negedge clk) ps_to_wdog = 1'b0;
        @(negedge clk) ps_to_wdog = 1'b1;
        @(negedge clk);
        ticks(BASE);
        chk(dev_rst, 1'b0, "R8 postscaler was cleared");
        ticks(BASE);
        chk(dev_rst, 1'b1, "R8 full scaled period");
        recover();

        // R8 tick together with clear is discarded
        @(negedge clk) ps_to_wdog = 1'b0;
        @(negedge clk) begin wd_tick = 1'b1; clr_wdog = 1'b1; end
        @(negedge clk) begin wd_tick = 1'b0; clr_wdog = 1'b0; end
        ticks(BASE - 1);
        chk(dev_rst, 1'b0, "R8 coincident tick dropped");
        ticks(1);
        chk(dev_rst, 1'b1, "R8 limit after drop");
        recover();

        // R5 disable freezes count
        ticks(2);
        wd_enable = 1'b0;
        ticks(12);
        chk(dev_rst, 1'b0, "R5 no timeout when disabled");
        wd_enable = 1'b1;
        ticks(BASE - 3);
        chk(dev_rst, 1'b0, "R5 count frozen not lost");
        ticks(1);
        chk(dev_rst, 1'b1, "R5 resumes from frozen count");
        recover();

        // R7 sleep restarts and wakes
        ticks(3);
        pulse_sleep();
        chk(to_flag, 1'b1, "R7 sleep leaves flag");
        ticks(BASE - 1);
        chk(dev_rst, 1'b0, "R7 full interval in sleep");
        ticks(1);
        chk(dev_rst, 1'b1, "R7 sleep timeout reset");
        chk(wake, 1'b1, "R7 wake with reset");
        @(negedge clk);
        chk(wake, 1'b0, "R7 wake one cycle");
        recover();

        // R6 clear restarts count
        ticks(BASE - 1);
        pulse_clr();
        ticks(BASE - 1);
        chk(dev_rst, 1'b0, "R6 clear restarted count");
        ticks(1);
        chk(dev_rst, 1'b1, "R6 limit after clear");
        recover();

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule